// File: doc/BRIEF.md
# Cascadable Presettable Modulo-16 Counter

This block is a synchronous binary up-counter, four bits wide by default, that wraps from its all-ones value back to zero. It can be preset from a parallel data word, which suits it to programmable frequency dividers. Counting is gated by two enables: a parallel enable and a trickle enable.

The block drives a carry flag. The flag is high when the count sits at its top value and the trickle enable is high. Several copies chain into one wider synchronous counter: each carry feeds the next stage's trickle enable, and all stages share the clock, the parallel enable and the load control.

A build-time parameter selects how the active-low clear acts. In one setting it clears the register at once, with no clock edge needed. In the other it is a synchronous control that acts on the rising edge.

Top module: `presettable_counter`

## Requirements
- R1: The count runs modulo 2^WIDTH. An increment from the all-ones value (4'hF by default) yields 4'h0.
- R2: With ASYNC_CLR=1, a low `rst_n` forces `count` to 0 and `carry_out` low at once, with no clock edge. A low `rst_n` overrides `load_n` and both enables at every edge while it stays low.
- R3: With ASYNC_CLR=0, a low `rst_n` leaves `count` unchanged until the next rising edge. At that edge it sets `count` to 0, even if a load or an increment is requested in the same cycle.
- R4: When the clear is inactive and `load_n` is low, `load_val` is copied into `count` on the rising edge, whatever the enables are.
- R5: When the clear and the load are inactive and both `en_par` and `en_trk` are high, `count` increases by one on the rising edge.
- R6: When the clear and the load are inactive and either enable is low, `count` holds.
- R7: `carry_out` is high exactly when `count` is all ones and `en_trk` is high. `en_par` has no effect on it.
- R8: `carry_out` follows `en_trk` combinationally within the same cycle, with no clock edge.
- R9: When one stage's `carry_out` drives the next stage's `en_trk` and the stages share `en_par`, a wrap of the low stage advances the high stage on the same edge.
- R10: With ASYNC_CLR=1, after `rst_n` is released the counter resumes normal loading and counting from the next rising edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low clear; asynchronous or synchronous according to ASYNC_CLR |
| load_n | input | 1 | Active-low parallel load request |
| load_val | input | WIDTH | Value to preset into the count |
| en_par | input | 1 | Parallel count enable |
| en_trk | input | 1 | Trickle count enable; also gates the carry |
| count | output | WIDTH | Current count value |
| carry_out | output | 1 | Terminal-count flag used to cascade stages |

## Verification
Two controls can be requested in the same cycle. In the synchronous-clear variant, a clear can arrive together with a parallel load. In either variant, a load can arrive while both count enables are high. The bench drives load with both enables high and expects the loaded value rather than an increment. It lowers the synchronous clear mid-cycle while a load of a nonzero value is pending, then checks two things: the count is unchanged before the edge, and it reads zero after the edge. The wrap of a low stage and the step of a chained high stage also fall on one edge; the bench judges both stage outputs together after that edge.

// File: rtl/cnt_pkg.sv
package cnt_pkg;
  typedef enum logic [1:0] {
    OP_HOLD  = 2'd0,
    OP_INC   = 2'd1,
    OP_LOAD  = 2'd2,
    OP_CLEAR = 2'd3
  } cnt_op_e;
endpackage

// File: rtl/cnt_ctrl.sv
// Resolves the control inputs into one operation, highest priority first.
module cnt_ctrl
  import cnt_pkg::*;
(
  input  logic    clr_req,
  input  logic    load_n,
  input  logic    en_par,
  input  logic    en_trk,
  output cnt_op_e op
);
  always_comb begin
    if (clr_req)              op = OP_CLEAR;
    else if (!load_n)         op = OP_LOAD;
    else if (en_par && en_trk) op = OP_INC;
    else                      op = OP_HOLD;
  end
endmodule

// File: rtl/cnt_next.sv
// Next-state value and its clock enable.
module cnt_next
  import cnt_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  cnt_op_e          op,
  input  logic [WIDTH-1:0] cur,
  input  logic [WIDTH-1:0] load_val,
  output logic [WIDTH-1:0] nxt,
  output logic             upd
);
  localparam logic [WIDTH-1:0] ONE = WIDTH'(1);

  always_comb begin
    upd = (op != OP_HOLD);
    unique case (op)
      OP_CLEAR: nxt = '0;
      OP_LOAD:  nxt = load_val;
      OP_INC:   nxt = cur + ONE;
      default:  nxt = cur;
    endcase
  end
endmodule

// File: rtl/cnt_state.sv
// Count register with asynchronous active-low clear and explicit enable.
module cnt_state #(
  parameter int WIDTH = 4
) (
  input  logic             clk,
  input  logic             arst_n,
  input  logic             upd,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n)  q <= '0;
    else if (upd) q <= d;
  end
endmodule

// File: rtl/cnt_tc.sv
// Terminal-count detect, gated by the trickle enable.
module cnt_tc #(
  parameter int WIDTH = 4
) (
  input  logic [WIDTH-1:0] cur,
  input  logic             en_trk,
  output logic             tc
);
  always_comb tc = en_trk & (&cur);
endmodule

// File: rtl/presettable_counter.sv
module presettable_counter
  import cnt_pkg::*;
#(
  parameter int WIDTH     = 4,
  parameter bit ASYNC_CLR = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_n,
  input  logic [WIDTH-1:0] load_val,
  input  logic             en_par,
  input  logic             en_trk,
  output logic [WIDTH-1:0] count,
  output logic             carry_out
);
  logic             clr_req;
  logic             arst_n;
  cnt_op_e          op;
  logic [WIDTH-1:0] nxt;
  logic             upd;

  generate
    if (ASYNC_CLR) begin : g_async_clr
      assign clr_req = 1'b0;
      assign arst_n  = rst_n;
    end else begin : g_sync_clr
      assign clr_req = ~rst_n;
      assign arst_n  = 1'b1;
    end
  endgenerate

  cnt_ctrl u_ctrl (
    .clr_req (clr_req),
    .load_n  (load_n),
    .en_par  (en_par),
    .en_trk  (en_trk),
    .op      (op)
  );

  cnt_next #(.WIDTH(WIDTH)) u_next (
    .op       (op),
    .cur      (count),
    .load_val (load_val),
    .nxt      (nxt),
    .upd      (upd)
  );

  cnt_state #(.WIDTH(WIDTH)) u_state (
    .clk    (clk),
    .arst_n (arst_n),
    .upd    (upd),
    .d      (nxt),
    .q      (count)
  );

  cnt_tc #(.WIDTH(WIDTH)) u_tc (
    .cur    (count),
    .en_trk (en_trk),
    .tc     (carry_out)
  );
endmodule

// File: rtl/cnt_chk.sv
module cnt_chk #(
  parameter int WIDTH     = 4,
  parameter bit ASYNC_CLR = 1'b1
) (
  input logic             clk,
  input logic             rst_n,
  input logic             load_n,
  input logic [WIDTH-1:0] load_val,
  input logic             en_par,
  input logic             en_trk,
  input logic [WIDTH-1:0] count,
  input logic             carry_out
);
  localparam logic [WIDTH-1:0] TOP = '1;
  localparam logic [WIDTH-1:0] ONE = WIDTH'(1);

  a_r1_wrap_to_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (load_n && en_par && en_trk && count == TOP) |=> (count == '0));

  a_r4_load_takes_value: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_n) |=> (count == $past(load_val)));

  a_r5_step_by_one: assert property (@(posedge clk) disable iff (!rst_n)
    (load_n && en_par && en_trk) |=> (count == WIDTH'($past(count) + ONE)));

  a_r6_hold_value: assert property (@(posedge clk) disable iff (!rst_n)
    (load_n && !(en_par && en_trk)) |=> $stable(count));

  a_r7_no_carry_without_trickle: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_trk) |-> (!carry_out));

  a_r7_carry_at_top: assert property (@(posedge clk) disable iff (!rst_n)
    (en_trk && count == TOP) |-> carry_out);

  a_r7_no_carry_below_top: assert property (@(posedge clk) disable iff (!rst_n)
    (count != TOP) |-> (!carry_out));

  generate
    if (ASYNC_CLR) begin : g_chk_async
      a_r2_clear_forces_zero: assert property (@(posedge clk)
        (!rst_n) |-> (count == '0 && !carry_out));
    end else begin : g_chk_sync
      a_r3_clear_on_edge: assert property (@(posedge clk)
        (!rst_n) |=> (count == '0));
    end
  endgenerate
endmodule

bind presettable_counter cnt_chk #(.WIDTH(WIDTH), .ASYNC_CLR(ASYNC_CLR)) u_cnt_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .load_n    (load_n),
  .load_val  (load_val),
  .en_par    (en_par),
  .en_trk    (en_trk),
  .count     (count),
  .carry_out (carry_out)
);

// File: tb/test_presettable_counter.sv
`timescale 1ns/1ps
module test_presettable_counter;
  logic       clk = 1'b0;
  logic       rst_n, rst_s_n, ld_n, par, trk;
  logic [3:0] lo_val, hi_val;
  logic [3:0] lo_q, hi_q, s_q;
  logic       lo_tc, hi_tc, s_tc;
  int         n_chk = 0;
  int         n_bad = 0;
  bit         done  = 1'b0;

  always #2 clk = ~clk;

  // low stage, async clear
  presettable_counter #(.WIDTH(4), .ASYNC_CLR(1'b1)) i_presettable_counter (
    .clk(clk), .rst_n(rst_n), .load_n(ld_n), .load_val(lo_val),
    .en_par(par), .en_trk(trk), .count(lo_q), .carry_out(lo_tc));

  // high stage, chained on the low stage carry (R9)
  presettable_counter #(.WIDTH(4), .ASYNC_CLR(1'b1)) i_presettable_counter_hi (
    .clk(clk), .rst_n(rst_n), .load_n(ld_n), .load_val(hi_val),
    .en_par(par), .en_trk(lo_tc), .count(hi_q), .carry_out(hi_tc));

  // synchronous clear variant, same controls as the low stage
  presettable_counter #(.WIDTH(4), .ASYNC_CLR(1'b0)) i_presettable_counter_sync (
    .clk(clk), .rst_n(rst_s_n), .load_n(ld_n), .load_val(lo_val),
    .en_par(par), .en_trk(trk), .count(s_q), .carry_out(s_tc));

  typedef struct packed {
    logic       ld_n;
    logic [3:0] lo_val;
    logic [3:0] hi_val;
    logic       par;
    logic       trk;
    logic [3:0] exp_lo;
    logic [3:0] exp_hi;
    logic       exp_tc;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t TBL [NV] = '{
    '{1'b0, 4'hE, 4'h3, 1'b0, 1'b0, 4'hE, 4'h3, 1'b0},
    '{1'b1, 4'h0, 4'h0, 1'b1, 1'b1, 4'hF, 4'h3, 1'b1},
    '{1'b1, 4'h0, 4'h0, 1'b1, 1'b1, 4'h0, 4'h4, 1'b0},
    '{1'b1, 4'h0, 4'h0, 1'b0, 1'b1, 4'h0, 4'h4, 1'b0},
    '{1'b0, 4'hF, 4'hF, 1'b0, 1'b1, 4'hF, 4'hF, 1'b1},
    '{1'b1, 4'h0, 4'h0, 1'b0, 1'b1, 4'hF, 4'hF, 1'b1},
    '{1'b1, 4'h0, 4'h0, 1'b1, 1'b0, 4'hF, 4'hF, 1'b0},
    '{1'b1, 4'h0, 4'h0, 1'b1, 1'b1, 4'h0, 4'h0, 1'b0},
    '{1'b0, 4'h7, 4'h9, 1'b1, 1'b1, 4'h7, 4'h9, 1'b0},
    '{1'b1, 4'h0, 4'h0, 1'b1, 1'b1, 4'h8, 4'h9, 1'b0}
  };

  function automatic string row_tag(input int i);
    case (i)
      0:       return "R4 load, enables low";
      1:       return "R5 R7 step to top";
      2:       return "R1 R9 wrap with ripple";
      3:       return "R6 hold, en_par low";
      4:       return "R4 R7 load top";
      5:       return "R6 R7 en_par no effect on carry";
      6:       return "R6 R7 hold, en_trk low";
      7:       return "R1 R9 both stages wrap";
      8:       return "R4 load beats count";
      default: return "R5 step after load";
    endcase
  endfunction

  task automatic chk(input string req, input string what,
                     input logic [3:0] got, input logic [3:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, got, exp);
    end
  endtask

  task automatic edge_and_settle();
    @(posedge clk);
    #1;
  endtask

  initial begin
    rst_n = 1'b1; rst_s_n = 1'b0; ld_n = 1'b1; par = 1'b0; trk = 1'b0;
    lo_val = 4'h0; hi_val = 4'h0;
    #1 rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk("R2", "reset lo count", lo_q, 4'h0);
    chk("R2", "reset hi count", hi_q, 4'h0);
    chk("R2", "reset carry", {3'b0, lo_tc}, 4'h0);
    chk("R3", "reset sync count", s_q, 4'h0);
    rst_n = 1'b1; rst_s_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      ld_n = TBL[i].ld_n; lo_val = TBL[i].lo_val; hi_val = TBL[i].hi_val;
      par = TBL[i].par; trk = TBL[i].trk;
      edge_and_settle();
      chk(row_tag(i), "lo count", lo_q, TBL[i].exp_lo);
      chk(row_tag(i), "hi count", hi_q, TBL[i].exp_hi);
      chk(row_tag(i), "sync count", s_q, TBL[i].exp_lo);
      chk(row_tag(i), "lo carry", {3'b0, lo_tc}, {3'b0, TBL[i].exp_tc});
    end

    // R2: clear between edges acts immediately
    @(negedge clk);
    ld_n = 1'b1; par = 1'b1; trk = 1'b1;
    edge_and_settle();
    chk("R5", "lo before clear", lo_q, 4'h9);
    rst_n = 1'b0;
    #0.5;
    chk("R2", "lo zero without edge", lo_q, 4'h0);
    chk("R2", "hi zero without edge", hi_q, 4'h0);
    chk("R2", "carry low in clear", {3'b0, lo_tc}, 4'h0);
    @(negedge clk);
    ld_n = 1'b0; lo_val = 4'h5; hi_val = 4'h6;
    edge_and_settle();
    chk("R2", "clear beats load", lo_q, 4'h0);
    chk("R2", "clear beats load hi", hi_q, 4'h0);
    @(negedge clk);
    rst_n = 1'b1; ld_n = 1'b1; par = 1'b1; trk = 1'b1;
    edge_and_settle();
    chk("R10", "count resumes after release", lo_q, 4'h1);

    // R7/R8: carry tracks en_trk with no edge
    @(negedge clk);
    ld_n = 1'b0; lo_val = 4'hF; hi_val = 4'h2; par = 1'b0; trk = 1'b0;
    edge_and_settle();
    chk("R7", "carry low with en_trk low at top", {3'b0, lo_tc}, 4'h0);
    trk = 1'b1;
    #0.5;
    chk("R8", "carry rises with en_trk", {3'b0, lo_tc}, 4'h1);
    chk("R8", "hi unchanged without edge", hi_q, 4'h2);
    trk = 1'b0;
    #0.5;
    chk("R8", "carry falls with en_trk", {3'b0, lo_tc}, 4'h0);

    // R3: synchronous clear waits for the edge and beats load
    @(negedge clk);
    rst_s_n = 1'b0; ld_n = 1'b0; lo_val = 4'h3; par = 1'b1; trk = 1'b1;
    #1;
    chk("R3", "sync count kept before edge", s_q, 4'hF);
    edge_and_settle();
    chk("R3", "sync clear beats load", s_q, 4'h0);
    chk("R4", "load beats count", lo_q, 4'h3);
    @(negedge clk);
    rst_s_n = 1'b1; ld_n = 1'b1;
    edge_and_settle();
    chk("R5", "sync count after clear", s_q, 4'h1);
    chk("R5", "lo count after load", lo_q, 4'h4);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end
endmodule